// File: doc/BRIEF.md
# Bus Cycle Timeout Monitor

This block guards an external bus against cycles that never finish. A master raises a cycle strobe for as long as a transfer is in progress. The addressed device ends the transfer by raising one of two acknowledges. One is a data-transfer acknowledge and the other is an autovector acknowledge. Either one is a valid response. The monitor counts the clocks of each cycle. If neither acknowledge has been seen when the count reaches the selected limit, the monitor pulls an active-low bus-error line. That line stays low until the master drops the strobe.

The limit is picked by a two-bit code. A higher code gives a shorter window. A monitor-enable input decides whether an overlong cycle raises an error at all. Both configuration inputs are taken on the first clock of each cycle. A later change to them only applies from the next cycle on, so a cycle in flight always runs against one fixed limit.

Top module: `bus_timeout_monitor`

## Requirements
- R1: While `rst` is high, and after it falls until the first timeout, `bus_err_n` is 1. Reset overrides the strobe and every other input.
- R2: A cycle starts at the first rising edge where `cyc_strobe` is sampled 1, after an edge where it was sampled 0 (or after reset). The edges of a cycle are numbered from 1. `lim_sel` picks the limit L: code 00 gives 64 clocks, 01 gives 32, 10 gives 16 and 11 gives 8. If neither acknowledge is sampled high at edges 1..L, `bus_err_n` goes to 0 right after edge L.
- R3: `data_ack` sampled 1 at any edge k < L of a cycle ends that cycle. No bus error follows for the rest of that cycle, even when the strobe stays high well past L.
- R4: `vec_ack` sampled 1 at any edge k < L ends the cycle in the same way as `data_ack`.
- R5: If an acknowledge is sampled 1 at exactly edge L, the acknowledge wins and `bus_err_n` stays 1.
- R6: Once low, `bus_err_n` stays 0 for as long as `cyc_strobe` is sampled 1. An acknowledge that arrives after the error does not clear it.
- R7: At the first edge where `cyc_strobe` is sampled 0, `bus_err_n` returns to 1 right after that edge. The next cycle counts again from edge 1.
- R8: If `mon_en` is 0 at edge 1 of a cycle, that cycle never produces a bus error, however long it lasts.
- R9: `lim_sel` and `mon_en` are sampled at edge 1 of each cycle. Changes to them at edges 2 and later of the same cycle have no effect on that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cyc_strobe | input | 1 | High for the duration of a bus cycle |
| data_ack | input | 1 | Data-transfer acknowledge, active high |
| vec_ack | input | 1 | Autovector acknowledge, active high |
| mon_en | input | 1 | Monitor enable, sampled at cycle start |
| lim_sel | input | 2 | Timeout select code, sampled at cycle start |
| bus_err_n | output | 1 | Bus error, active low |

## Verification
All outputs are registered. `bus_err_n` changes on the same rising edge that samples its cause: edge L for a timeout, and the first strobe-low edge for the release. The bench changes inputs on falling edges only. It reads `bus_err_n` one time unit after every rising edge of a cycle, so each edge number is checked against the expected error edge, which the bench computes as 64 shifted right by the code. Every code is swept against no acknowledge, early acknowledges of both kinds, an acknowledge on the limit edge, a late acknowledge, disabled cycles, and configuration changes in mid-cycle.

// File: rtl/bto_pkg.sv
package bto_pkg;

    typedef logic [1:0] lim_code_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_DONE  = 2'd2,
        ST_FAULT = 2'd3
    } mon_state_t;

    typedef struct packed {
        logic      en;
        lim_code_t code;
    } mon_cfg_t;

    // Counter width able to hold the longest window.
    function automatic int unsigned cnt_width(input int unsigned base);
        return $clog2(base + 1);
    endfunction

    // Window length for a select code: halves as the code rises.
    function automatic int unsigned window_of(input int unsigned base, input int unsigned code);
        return base >> code;
    endfunction

endpackage

// File: rtl/bto_limit_sel.sv
module bto_limit_sel
    import bto_pkg::*;
#(
    parameter int unsigned BASE_LIMIT = 64,
    parameter int unsigned CNT_W      = 7
) (
    input  lim_code_t          code,
    output logic [CNT_W-1:0]   limit
);
    localparam int unsigned N_CODES = 1 << $bits(lim_code_t);

    logic [CNT_W-1:0] table_q [N_CODES];

    for (genvar i = 0; i < N_CODES; i++) begin : g_tbl
        assign table_q[i] = CNT_W'(window_of(BASE_LIMIT, i));
    end

    assign limit = table_q[code];
endmodule

// File: rtl/bto_cfg_latch.sv
module bto_cfg_latch
    import bto_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  mon_cfg_t live_cfg,
    output mon_cfg_t eff_cfg
);
    mon_cfg_t held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
        end else if (start) begin
            held_q <= live_cfg;
        end
    end

    // On the first edge the live settings apply; afterwards the captured ones.
    assign eff_cfg = start ? live_cfg : held_q;
endmodule

// File: rtl/bto_cycle_counter.sv
module bto_cycle_counter #(
    parameter int unsigned CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             advance,
    input  logic [CNT_W-1:0] limit,
    output logic             reach
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   cnt_inc;

    assign cnt_inc = {1'b0, cnt_q} + (CNT_W+1)'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CNT_ONE;
        end else if (advance && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_inc[CNT_W-1:0];
        end
    end

    // True when the edge now being sampled is the limit-th edge of the cycle (or later).
    always_comb begin
        if (start) begin
            reach = (limit <= CNT_ONE);
        end else begin
            reach = (cnt_inc >= {1'b0, limit});
        end
    end
endmodule

// File: rtl/bto_fsm.sv
module bto_fsm
    import bto_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       strobe,
    input  logic       ack,
    input  logic       en,
    input  logic       reach,
    output logic       start,
    output logic       advance,
    output mon_state_t state
);
    mon_state_t state_q, state_d;

    assign start   = (state_q == ST_IDLE) && strobe;
    assign advance = (state_q == ST_WAIT) && strobe && !ack;
    assign state   = state_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (strobe) begin
                    if (ack)              state_d = ST_DONE;
                    else if (en && reach) state_d = ST_FAULT;
                    else                  state_d = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (!strobe)              state_d = ST_IDLE;
                else if (ack)             state_d = ST_DONE;
                else if (en && reach)     state_d = ST_FAULT;
            end
            ST_DONE: begin
                if (!strobe)              state_d = ST_IDLE;
            end
            ST_FAULT: begin
                if (!strobe)              state_d = ST_IDLE;
            end
            default:                      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end
endmodule

// File: rtl/bus_timeout_monitor.sv
module bus_timeout_monitor
    import bto_pkg::*;
#(
    parameter int unsigned BASE_LIMIT = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cyc_strobe,
    input  logic       data_ack,
    input  logic       vec_ack,
    input  logic       mon_en,
    input  logic [1:0] lim_sel,
    output logic       bus_err_n
);
    localparam int unsigned CNT_W = cnt_width(BASE_LIMIT);

    logic             any_ack;
    logic             start;
    logic             advance;
    logic             reach;
    logic [CNT_W-1:0] limit_eff;
    logic             eff_en;
    mon_cfg_t         live_cfg;
    mon_cfg_t         eff_cfg;
    mon_state_t       state;

    assign any_ack  = data_ack | vec_ack;
    assign live_cfg = '{en: mon_en, code: lim_sel};
    assign eff_en   = eff_cfg.en;

    bto_cfg_latch u_cfg (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .live_cfg (live_cfg),
        .eff_cfg  (eff_cfg)
    );

    bto_limit_sel #(
        .BASE_LIMIT (BASE_LIMIT),
        .CNT_W      (CNT_W)
    ) u_lim (
        .code  (eff_cfg.code),
        .limit (limit_eff)
    );

    bto_cycle_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .advance (advance),
        .limit   (limit_eff),
        .reach   (reach)
    );

    bto_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .strobe  (cyc_strobe),
        .ack     (any_ack),
        .en      (eff_en),
        .reach   (reach),
        .start   (start),
        .advance (advance),
        .state   (state)
    );

    assign bus_err_n = (state != ST_FAULT);
endmodule

// File: rtl/bto_checker.sv
module bto_checker #(
    parameter int unsigned CNT_W = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             cyc_strobe,
    input logic             data_ack,
    input logic             vec_ack,
    input logic             eff_en,
    input logic [CNT_W-1:0] limit_eff,
    input logic             bus_err_n
);
    // Edges seen with the strobe high since it was last low, saturating.
    logic [CNT_W:0] run_q;

    always_ff @(posedge clk) begin
        if (rst || !cyc_strobe)  run_q <= '0;
        else if (run_q != '1)    run_q <= run_q + 1'b1;
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> bus_err_n);

    assert_window_len_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_err_n) |-> (run_q == {1'b0, $past(limit_eff)}));

    assert_ack_no_err_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_err_n && (data_ack || vec_ack)) |=> bus_err_n);

    assert_err_held_R6: assert property (@(posedge clk) disable iff (rst)
        (!bus_err_n && cyc_strobe) |=> !bus_err_n);

    assert_release_R7: assert property (@(posedge clk) disable iff (rst)
        !cyc_strobe |=> bus_err_n);

    assert_disabled_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_err_n) |-> $past(eff_en));
endmodule

bind bus_timeout_monitor bto_checker #(
    .CNT_W (CNT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cyc_strobe (cyc_strobe),
    .data_ack   (data_ack),
    .vec_ack    (vec_ack),
    .eff_en     (eff_en),
    .limit_eff  (limit_eff),
    .bus_err_n  (bus_err_n)
);

// File: tb/bus_timeout_monitor_tb.sv
module bus_timeout_monitor_tb;
    localparam int CLK_PERIOD = 10;
    localparam int BASE       = 64;
    localparam int WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cyc_strobe = 1'b0;
    logic       data_ack = 1'b0;
    logic       vec_ack = 1'b0;
    logic       mon_en = 1'b0;
    logic [1:0] lim_sel = 2'b00;
    logic       bus_err_n;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_timeout_monitor #(.BASE_LIMIT(BASE)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .cyc_strobe (cyc_strobe),
        .data_ack   (data_ack),
        .vec_ack    (vec_ack),
        .mon_en     (mon_en),
        .lim_sel    (lim_sel),
        .bus_err_n  (bus_err_n)
    );

    task automatic check(input string tag, input logic exp, input int edge_no);
        checks++;
        if (bus_err_n !== exp) begin
            errors++;
            $display("FAIL %s edge %0d: bus_err_n actual %b expected %b", tag, edge_no, bus_err_n, exp);
        end
    endtask

    // kind: 0 no ack, 1 data_ack, 2 vec_ack. ack_at: first edge with ack high (0 = never).
    task automatic run_cycle(input logic [1:0] sel, input logic en,
                             input logic [1:0] sel2, input logic en2,
                             input int kind, input int ack_at, input int hold,
                             input string tag);
        int lim;
        int err_edge;
        lim = BASE >> sel;
        err_edge = (en && (kind == 0 || ack_at == 0 || ack_at > lim)) ? lim : 0;
        @(negedge clk);
        cyc_strobe = 1'b1;
        lim_sel    = sel;
        mon_en     = en;
        data_ack   = (kind == 1 && ack_at == 1);
        vec_ack    = (kind == 2 && ack_at == 1);
        for (int j = 1; j <= hold; j++) begin
            @(posedge clk);
            #1;
            check(tag, (err_edge != 0 && j >= err_edge) ? 1'b0 : 1'b1, j);
            @(negedge clk);
            lim_sel  = sel2;
            mon_en   = en2;
            data_ack = (kind == 1 && ack_at != 0 && j + 1 >= ack_at);
            vec_ack  = (kind == 2 && ack_at != 0 && j + 1 >= ack_at);
        end
        cyc_strobe = 1'b0;
        data_ack   = 1'b0;
        vec_ack    = 1'b0;
        @(posedge clk);
        #1;
        check("R7 release", 1'b1, hold + 1);
    endtask

    initial begin
        // R1: reset overrides an active, enabled, short-window strobe.
        cyc_strobe = 1'b1;
        mon_en     = 1'b1;
        lim_sel    = 2'b11;
        for (int k = 0; k < 12; k++) begin
            @(posedge clk);
            #1;
            check("R1 in reset", 1'b1, k);
        end
        @(negedge clk);
        cyc_strobe = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check("R1 after reset", 1'b1, 0);

        for (int s = 0; s < 4; s++) begin
            logic [1:0] sc;
            int L;
            sc = 2'(s);
            L  = BASE >> s;
            run_cycle(sc, 1'b1, sc, 1'b1, 0, 0,     L + 3, "R2 timeout");
            run_cycle(sc, 1'b1, sc, 1'b1, 1, L - 1, L + 3, "R3 data ack early");
            run_cycle(sc, 1'b1, sc, 1'b1, 1, 1,     L + 2, "R3 data ack first edge");
            run_cycle(sc, 1'b1, sc, 1'b1, 2, L - 1, L + 3, "R4 vec ack early");
            run_cycle(sc, 1'b1, sc, 1'b1, 2, 2,     L + 2, "R4 vec ack second edge");
            run_cycle(sc, 1'b1, sc, 1'b1, 1, L,     L + 3, "R5 data ack on limit");
            run_cycle(sc, 1'b1, sc, 1'b1, 2, L,     L + 3, "R5 vec ack on limit");
            run_cycle(sc, 1'b1, sc, 1'b1, 1, L + 2, L + 5, "R6 late ack");
            run_cycle(sc, 1'b0, sc, 1'b0, 0, 0,     L + 6, "R8 disabled");
            run_cycle(sc, 1'b1, ~sc, 1'b0, 0, 0,    L + 2, "R9 change after start");
            run_cycle(sc, 1'b0, 2'b11, 1'b1, 0, 0,  L + 4, "R9 enable after start");
            run_cycle(sc, 1'b1, sc, 1'b1, 0, 0,     L + 1, "R7 restart count");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not end, actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule